// File: doc/BRIEF.md
# HDLC Frame Transmitter with Collision Retry

This block turns bytes that a host has written into a bit-serial HDLC frame. A host loads a byte FIFO and issues a transmit-start command together with, or followed by, a message-end command. The transmitter then sends an opening flag and the bytes, inserting a zero after every run of five ones. When the FIFO runs dry after message-end, it appends a 16-bit frame check sequence and a closing flag. Outside a frame the line rests at continuous ones. One bit leaves the block for each pulse on the bit-enable input, so the line rate is set outside the block.

A transparent mode sends the FIFO bytes exactly as written, with no flags, no check sequence and no zero insertion. A collision input abandons the frame in progress. The block then holds the line at ones and raises a sticky collision interrupt. The host recovers with a fixed handshake: transmitter reset, wait for FIFO ready, reload the frame, and start again. A FIFO-ready interrupt tells the host that a frame completed or that a reset took place.

Top module: `hdlc_tx_retry`

## Requirements
- R1: After the synchronous reset or a transmitter-reset command, the FIFO is empty, irq_ready is 1, irq_collision is 0 and line_out is 1.
- R2: Outside a frame, line_out is 1. line_out changes only on a clock edge where bit_en is high, except for a collision abort or a reset.
- R3: One bit leaves per bit_en pulse, least significant bit of each byte first. The first bit_en after transmit-start still sends a fill 1, and frame bits follow from the next pulse.
- R4: In HDLC mode a frame is: opening flag 0x7E, the data bytes, the check sequence, closing flag 0x7E. Flags are never zero-stuffed.
- R5: In HDLC mode a 0 is inserted after any five consecutive 1s in the data and check-sequence bits. This includes a run that ends on the last check-sequence bit, so the stuffed 0 comes before the closing flag.
- R6: The check sequence is the CRC with polynomial x^16+x^12+x^5+1. It is computed bit-serially over the data bits in transmit order, in reflected form with constant 0x8408 and preset 0xFFFF. Its ones complement is sent low byte first, each byte least significant bit first. An empty frame therefore carries sixteen 0s.
- R7: In transparent mode (mode_transparent=1 at transmit-start) the FIFO bytes are sent unmodified, LSB first, with no flags, no check sequence and no inserted zeros. The line then returns to 1s.
- R8: transmit-start clears irq_ready. A frame ends once the FIFO is empty after message-end has been given, and irq_ready sets on the edge that sends the last closing-flag bit (HDLC) or the last data bit (transparent).
- R9: A collision while a frame is in progress sets line_out to 1 on the next edge and sets irq_collision. irq_collision stays set until a transmitter reset, and irq_ready stays 0. During that time the line stays at 1 and transmit-start commands are ignored.
- R10: The transmitter reset discards all bytes left in the FIFO. A frame rewritten and restarted after it is sent in full from its opening flag.
- R11: A write while the FIFO already holds FIFO_DEPTH (default 16) bytes is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One pulse per transmitted bit |
| wr_en | input | 1 | Write strobe into the transmit FIFO |
| wr_data | input | 8 | Byte to be written |
| cmd_send | input | 1 | Transmit-start command (one-cycle pulse) |
| cmd_end | input | 1 | Message-end command (one-cycle pulse) |
| cmd_reset | input | 1 | Transmitter reset command (one-cycle pulse) |
| mode_transparent | input | 1 | 1 selects transparent mode, sampled at transmit-start |
| collision | input | 1 | Collision detected on the line |
| line_out | output | 1 | Serial transmit data |
| irq_ready | output | 1 | FIFO-ready interrupt (level) |
| irq_collision | output | 1 | Collision interrupt (level, sticky) |

## Verification
The hardest case to reach is a run of five ones that ends exactly on the last check-sequence bit, because the data must be chosen so that the CRC itself ends in such a run. Random frame contents with many bytes of 0xFF therefore run next to directed all-ones and flag-valued frames, and every frame is compared bit by bit against a stream built independently in the bench. The collision recovery is driven as the full host sequence. The collision lands mid-byte in the data phase and is followed by an ignored restart, the reset, an empty transparent send that shows the FIFO was flushed, and finally the rewritten frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned CRC_W      = 16;
    localparam int unsigned STUFF_RUN  = 5;
    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [CRC_W-1:0]  CRC_PRESET = 16'hFFFF;
    localparam logic [CRC_W-1:0]  CRC_REFL   = 16'h8408;
    localparam int unsigned BCNT_W     = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_DATA,
        S_HOLD,
        S_FCS,
        S_CLOSE,
        S_ABORT
    } tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [BYTE_W-1:0]  sh;
        logic [BCNT_W-1:0]  bcnt;
        logic [2:0]         ones;
        logic [CRC_W-1:0]   crc;
        logic               fcs_hi;
        logic               line;
    } tx_regs_t;

    typedef struct packed {
        logic armed;
        logic endr;
        logic transp;
        logic rdy;
        logic col;
    } tx_ctl_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_REFL : '0);
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    input  logic              pop,
    output logic [BYTE_W-1:0] dout,
    output logic              empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [AW:0]       count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign do_push = push && (count != FULL_CNT);
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              bit_en,
    input  logic              armed,
    input  logic              end_req,
    input  logic              transparent,
    input  logic              collision,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              line_out,
    output logic              frame_done,
    output logic              abort_evt,
    output logic              eng_idle
);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);
    localparam logic [2:0]        RUN_MAX  = 3'(STUFF_RUN);

    tx_regs_t r, n;

    logic             stuff_now, last_bit, want_byte;
    logic [CRC_W-1:0] crc_nx, crc_base;
    logic [2:0]       ones_cnt;

    always_comb begin
        stuff_now = !transparent && (r.ones == RUN_MAX)
                    && (r.st inside {S_DATA, S_FCS, S_CLOSE});
        last_bit  = (r.bcnt == LAST_BIT);
        crc_nx    = crc_step(r.crc, r.sh[0]);
        crc_base  = (r.st == S_DATA) ? crc_nx : r.crc;
        ones_cnt  = r.sh[0] ? (r.ones + 3'd1) : 3'd0;
    end

    always_comb begin
        n          = r;
        fifo_pop   = 1'b0;
        frame_done = 1'b0;
        abort_evt  = 1'b0;
        want_byte  = 1'b0;
        if (collision && (r.st != S_IDLE) && (r.st != S_ABORT)) begin
            n.st      = S_ABORT;
            n.line    = 1'b1;
            abort_evt = 1'b1;
        end else if (bit_en) begin
            unique case (r.st)
                S_IDLE: begin
                    n.line = 1'b1;
                    if (armed) begin
                        if (transparent) begin
                            want_byte = 1'b1;
                        end else begin
                            n.st   = S_OPEN;
                            n.sh   = FLAG_BYTE;
                            n.bcnt = '0;
                            n.ones = '0;
                            n.crc  = CRC_PRESET;
                        end
                    end
                end
                S_OPEN: begin
                    n.line    = r.sh[0];
                    n.sh      = r.sh >> 1;
                    n.bcnt    = r.bcnt + 1'b1;
                    want_byte = last_bit;
                end
                S_DATA, S_FCS: begin
                    if (stuff_now) begin
                        n.line = 1'b0;
                        n.ones = '0;
                    end else begin
                        n.line = r.sh[0];
                        n.sh   = r.sh >> 1;
                        n.bcnt = r.bcnt + 1'b1;
                        n.ones = transparent ? 3'd0 : ones_cnt;
                        if (r.st == S_DATA) begin
                            n.crc     = crc_nx;
                            want_byte = last_bit;
                        end else if (last_bit) begin
                            if (!r.fcs_hi) begin
                                n.sh     = ~r.crc[CRC_W-1:BYTE_W];
                                n.fcs_hi = 1'b1;
                            end else begin
                                n.st = S_CLOSE;
                                n.sh = FLAG_BYTE;
                            end
                        end
                    end
                end
                S_HOLD: begin
                    n.line    = 1'b1;
                    n.ones    = '0;
                    want_byte = 1'b1;
                end
                S_CLOSE: begin
                    if (stuff_now) begin
                        n.line = 1'b0;
                        n.ones = '0;
                    end else begin
                        n.line = r.sh[0];
                        n.sh   = r.sh >> 1;
                        n.bcnt = r.bcnt + 1'b1;
                        if (last_bit) begin
                            n.st       = S_IDLE;
                            frame_done = 1'b1;
                        end
                    end
                end
                S_ABORT: begin
                    n.line = 1'b1;
                end
                default: begin
                    n.st   = S_IDLE;
                    n.line = 1'b1;
                end
            endcase

            if (want_byte) begin
                n.bcnt = '0;
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    n.st     = S_DATA;
                    n.sh     = fifo_data;
                end else if (end_req) begin
                    if (transparent) begin
                        n.st       = S_IDLE;
                        frame_done = 1'b1;
                    end else begin
                        n.st     = S_FCS;
                        n.sh     = ~crc_base[BYTE_W-1:0];
                        n.crc    = crc_base;
                        n.fcs_hi = 1'b0;
                    end
                end else begin
                    n.st = S_HOLD;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            r <= '{st: S_IDLE, sh: '0, bcnt: '0, ones: '0,
                   crc: CRC_PRESET, fcs_hi: 1'b0, line: 1'b1};
        end else begin
            r <= n;
        end
    end

    assign line_out = r.line;
    assign eng_idle = (r.st == S_IDLE);

endmodule

// File: rtl/hdlc_tx_retry.sv
module hdlc_tx_retry
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cmd_send,
    input  logic              cmd_end,
    input  logic              cmd_reset,
    input  logic              mode_transparent,
    input  logic              collision,
    output logic              line_out,
    output logic              irq_ready,
    output logic              irq_collision
);
    tx_ctl_t           c;
    logic              fifo_pop, fifo_empty;
    logic [BYTE_W-1:0] fifo_data;
    logic              frame_done, abort_evt, eng_idle;
    logic              send_ok;

    assign send_ok = cmd_send && eng_idle && !c.armed;

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (cmd_reset),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (fifo_pop),
        .dout  (fifo_data),
        .empty (fifo_empty)
    );

    hdlc_tx_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .flush       (cmd_reset),
        .bit_en      (bit_en),
        .armed       (c.armed),
        .end_req     (c.endr),
        .transparent (c.transp),
        .collision   (collision),
        .fifo_empty  (fifo_empty),
        .fifo_data   (fifo_data),
        .fifo_pop    (fifo_pop),
        .line_out    (line_out),
        .frame_done  (frame_done),
        .abort_evt   (abort_evt),
        .eng_idle    (eng_idle)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd_reset) begin
            c <= '{armed: 1'b0, endr: 1'b0, transp: 1'b0, rdy: 1'b1, col: 1'b0};
        end else begin
            if (frame_done) begin
                c.armed <= 1'b0;
                c.endr  <= 1'b0;
                c.rdy   <= 1'b1;
            end
            if (abort_evt) begin
                c.armed <= 1'b0;
                c.endr  <= 1'b0;
                c.col   <= 1'b1;
            end
            if (send_ok) begin
                c.armed  <= 1'b1;
                c.transp <= mode_transparent;
                c.rdy    <= 1'b0;
                c.endr   <= cmd_end;
            end else if (cmd_end && c.armed) begin
                c.endr <= 1'b1;
            end
        end
    end

    assign irq_ready     = c.rdy;
    assign irq_collision = c.col;

endmodule

// File: rtl/hdlc_tx_retry_chk.sv
module hdlc_tx_retry_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic collision,
    input logic cmd_send,
    input logic cmd_reset,
    input logic line_out,
    input logic irq_ready,
    input logic irq_collision
);
    // R1
    reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (irq_ready && !irq_collision && line_out));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !collision && !cmd_reset) |=> $stable(line_out));

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_ready) |-> $past(cmd_send));

    // R9
    col_line_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_collision) |-> line_out);

    // R9
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_collision && !cmd_reset) |=> irq_collision);

    // R9
    col_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        irq_collision |-> !irq_ready);

endmodule

bind hdlc_tx_retry hdlc_tx_retry_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .collision     (collision),
    .cmd_send      (cmd_send),
    .cmd_reset     (cmd_reset),
    .line_out      (line_out),
    .irq_ready     (irq_ready),
    .irq_collision (irq_collision)
);

// File: tb/tb_hdlc_tx_retry.sv
`timescale 1ns/1ps
module tb_hdlc_tx_retry;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_send = 1'b0;
    logic       cmd_end = 1'b0;
    logic       cmd_reset = 1'b0;
    logic       mode_transparent = 1'b0;
    logic       collision = 1'b0;
    logic       line_out, irq_ready, irq_collision;

    int total = 0;
    int fails = 0;

    bit       exp_q[$];
    bit [7:0] dq[$];

    always #10 clk = ~clk;

    hdlc_tx_retry dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_send(cmd_send), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
        .mode_transparent(mode_transparent), .collision(collision),
        .line_out(line_out), .irq_ready(irq_ready), .irq_collision(irq_collision)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(output bit b);
        @(negedge clk); bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0; b = line_out;
    endtask

    task automatic write_byte(input bit [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_send(input bit transp, input bit with_end);
        @(negedge clk); mode_transparent = transp; cmd_send = 1'b1; cmd_end = with_end;
        @(negedge clk); cmd_send = 1'b0; cmd_end = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); cmd_end = 1'b1;
        @(negedge clk); cmd_end = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); cmd_reset = 1'b1;
        @(negedge clk); cmd_reset = 1'b0;
    endtask

    function automatic bit [15:0] crc_bit(input bit [15:0] c, input bit b);
        return (c[0] ^ b) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    endfunction

    task automatic push_flag();
        for (int i = 0; i < 8; i++) exp_q.push_back(((8'h7E >> i) & 1) != 0);
    endtask

    task automatic build_hdlc();
        int ones = 0;
        bit [15:0] crc = 16'hFFFF;
        bit [15:0] fcs;
        bit b;
        exp_q.delete();
        exp_q.push_back(1'b1);
        push_flag();
        foreach (dq[k]) begin
            for (int i = 0; i < 8; i++) begin
                b = dq[k][i];
                crc = crc_bit(crc, b);
                exp_q.push_back(b);
                ones = b ? ones + 1 : 0;
                if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
            end
        end
        fcs = ~crc;
        for (int i = 0; i < 16; i++) begin
            b = fcs[i];
            exp_q.push_back(b);
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
        end
        push_flag();
    endtask

    task automatic build_transp();
        exp_q.delete();
        exp_q.push_back(1'b1);
        foreach (dq[k])
            for (int i = 0; i < 8; i++) exp_q.push_back(dq[k][i]);
    endtask

    task automatic load_dq();
        foreach (dq[k]) write_byte(dq[k]);
    endtask

    task automatic run_check(input string req, input string what);
        int n = exp_q.size();
        int mism = 0;
        bit b, e;
        for (int i = 0; i < n + 4; i++) begin
            tick(b);
            e = (i < n) ? exp_q[i] : 1'b1;
            if (b != e) mism++;
        end
        chk(mism == 0, req, {what, " bit mismatches"}, mism, 0);
        chk(irq_ready == 1'b1, "R8", {what, " ready after frame"}, int'(irq_ready), 1);
    endtask

    task automatic hdlc_frame(input string req, input string what);
        load_dq();
        build_hdlc();
        pulse_send(1'b0, 1'b1);
        run_check(req, what);
    endtask

    task automatic rand_dq(input int maxlen, input bit heavy_ones);
        int len = $urandom_range(maxlen, 1);
        dq.delete();
        for (int i = 0; i < len; i++) begin
            if (heavy_ones && ($urandom_range(1, 0) == 1)) dq.push_back(8'hFF);
            else dq.push_back(8'($urandom));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit b;
        int bad;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(line_out == 1'b1, "R1", "line after reset", int'(line_out), 1);
        chk(irq_ready == 1'b1, "R1", "ready after reset", int'(irq_ready), 1);
        chk(irq_collision == 1'b0, "R1", "collision after reset", int'(irq_collision), 0);

        // R2 idle fill
        bad = 0;
        for (int i = 0; i < 10; i++) begin tick(b); if (b != 1'b1) bad++; end
        chk(bad == 0, "R2", "idle fill zeros", bad, 0);

        // R3 R4 single byte
        dq = '{8'h55};
        hdlc_frame("R3", "single 0x55");

        // R5 all ones bytes
        dq = '{8'hFF, 8'hFF, 8'hFF};
        hdlc_frame("R5", "all ones");

        // R6 empty frame: FCS is sixteen zeros
        dq.delete();
        hdlc_frame("R6", "empty frame");

        // R4 flag-valued data is stuffed, real flags are not
        dq = '{8'h7E, 8'h7E};
        hdlc_frame("R4", "flag data");

        // R6 R5 random frames
        for (int f = 0; f < 8; f++) begin
            rand_dq(8, f[0]);
            hdlc_frame("R6", "random hdlc");
        end

        // R8 message-end given after transmit-start
        dq = '{8'hA3, 8'h0F};
        load_dq();
        build_hdlc();
        pulse_send(1'b0, 1'b0);
        chk(irq_ready == 1'b0, "R8", "ready cleared by start", int'(irq_ready), 0);
        pulse_end();
        run_check("R8", "late end");

        // R7 transparent mode
        dq = '{8'hFF, 8'hFF, 8'h7E};
        load_dq();
        build_transp();
        pulse_send(1'b1, 1'b1);
        run_check("R7", "transparent ones");
        for (int f = 0; f < 3; f++) begin
            rand_dq(6, 1'b0);
            load_dq();
            build_transp();
            pulse_send(1'b1, 1'b1);
            run_check("R7", "random transparent");
        end

        // R11 overflow: 17 writes, 16 kept
        dq.delete();
        for (int i = 0; i < 17; i++) write_byte(8'(i * 7 + 1));
        for (int i = 0; i < 16; i++) dq.push_back(8'(i * 7 + 1));
        build_transp();
        pulse_send(1'b1, 1'b1);
        run_check("R11", "fifo overflow");

        // R9 collision mid-frame
        dq = '{8'h00, 8'h3C, 8'hC3, 8'h99};
        load_dq();
        pulse_send(1'b0, 1'b1);
        for (int i = 0; i < 12; i++) tick(b);
        @(negedge clk); collision = 1'b1;
        @(negedge clk); collision = 1'b0;
        chk(line_out == 1'b1, "R9", "line after collision", int'(line_out), 1);
        chk(irq_collision == 1'b1, "R9", "collision irq", int'(irq_collision), 1);
        chk(irq_ready == 1'b0, "R9", "ready during abort", int'(irq_ready), 0);
        bad = 0;
        for (int i = 0; i < 6; i++) begin tick(b); if (b != 1'b1) bad++; end
        chk(bad == 0, "R9", "line held after abort", bad, 0);
        pulse_send(1'b0, 1'b1);
        bad = 0;
        for (int i = 0; i < 12; i++) begin tick(b); if (b != 1'b1) bad++; end
        chk(bad == 0, "R9", "start ignored while aborted", bad, 0);
        chk(irq_collision == 1'b1, "R9", "collision irq sticky", int'(irq_collision), 1);

        // R1 R10 transmitter reset
        pulse_reset();
        chk(irq_ready == 1'b1, "R1", "ready after tx reset", int'(irq_ready), 1);
        chk(irq_collision == 1'b0, "R1", "collision cleared", int'(irq_collision), 0);
        chk(line_out == 1'b1, "R1", "line after tx reset", int'(line_out), 1);

        // R10 FIFO flushed: an empty transparent send carries no data
        dq.delete();
        build_transp();
        pulse_send(1'b1, 1'b1);
        run_check("R10", "flushed fifo");

        // R10 rewrite and restart
        dq = '{8'h00, 8'h3C, 8'hC3, 8'h99};
        hdlc_frame("R10", "retransmission");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule